// File: doc/BRIEF.md
# Serial Port Interrupt Status and Mask Unit

This unit sits beside the receive and transmit FIFOs of a serial controller. It turns their occupancy into a live status word. It collects FIFO conditions and one-cycle error and event pulses into a sticky interrupt status register. It combines that register with an interrupt mask to drive a single level-sensitive interrupt line. Software reads and updates the unit through a plain register port. The mask has two write addresses: one sets mask bits and one clears them. The mask's own address can be read but does not accept writes.

The RX and TX trigger levels are held here as two small registers. They reset to 32, and the live word compares the occupancy counts against them. The TX-trigger condition appears at bit 13 of the live word and at bit 10 of the sticky register; the remaining FIFO conditions keep the same position in both. The register port is a control path with no flow control, so it has no valid/ready pair. A write takes effect at the clock edge where `wr_en_i` is high. `rd_data_o` follows `addr_i` combinationally.

Top module: `uart_isu_top`

Address map (3-bit `addr_i`): 0 mask-set, 1 mask-clear, 2 mask (read only), 3 sticky status (write 1 to clear), 4 live status (read only), 5 RX trigger level, 6 TX trigger level, 7 unused.

## Requirements
- R1: Live status word (address 4), bit by bit: bit 1 is high when RX count is 0. Bit 3 is high when TX count is 0. Bit 2 is high when RX count equals DEPTH. Bit 4 is high when TX count equals DEPTH. Bit 0 is high when RX count is greater than or equal to the RX trigger level. The live word follows the counts within the same cycle.
- R2: The condition TX count greater than or equal to the TX trigger level drives live bit 13. Through the clock edge, it sets sticky bit 10. Sticky bit 13 is never set.
- R3: Any live bit among 4..0 that is high at a clock edge sets the same sticky bit. A sticky bit stays set until software clears it.
- R4: Writing address 3 clears every sticky bit written as 1, unless a set source for that bit is active in the same cycle.
- R5: A write to address 0 ORs `wr_data_i` into the mask. A write to address 1 clears the mask bits written as 1. A write to address 2 leaves the mask unchanged. The mask reads back at address 2.
- R6: Each event pulse at a clock edge sets one sticky bit: parity error bit 7, framing error bit 6, RX overrun bit 5, TX overrun bit 12, modem-status change bit 9, RX timeout bit 8.
- R7: `irq_o` is high exactly when the mask AND the sticky register is nonzero.
- R8: After reset the mask and the sticky register read 0, and both trigger registers read 32.
- R9: When an event pulse and a write-1-to-clear hit the same sticky bit in the same cycle, the bit stays set.
- R10: Reads return 32 bits with unused bits as 0. Trigger registers take `wr_data_i[CNT_W-1:0]`. Address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_count_i | input | CNT_W | RX FIFO occupancy |
| tx_count_i | input | CNT_W | TX FIFO occupancy |
| evt_rx_ovr_i | input | 1 | RX overrun pulse |
| evt_frame_i | input | 1 | Framing error pulse |
| evt_parity_i | input | 1 | Parity error pulse |
| evt_timeout_i | input | 1 | RX timeout pulse |
| evt_modem_i | input | 1 | Modem status change pulse |
| evt_tx_ovr_i | input | 1 | TX overrun pulse |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for addr_i |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds the unit with its default DEPTH of 64, so CNT_W is 7. At that depth the reset trigger level of 32 sits mid-range. The full and empty conditions and both sides of each trigger comparison can therefore all be driven at the count ports. A trigger of 8 is also written, to show the RX comparison moving with its register.

// File: rtl/uart_isu_pkg.sv
package uart_isu_pkg;
  localparam int REG_W = 32;

  typedef enum logic [2:0] {
    A_MSET  = 3'd0,
    A_MCLR  = 3'd1,
    A_MASK  = 3'd2,
    A_STAT  = 3'd3,
    A_LIVE  = 3'd4,
    A_RXTRG = 3'd5,
    A_TXTRG = 3'd6,
    A_NONE  = 3'd7
  } isu_addr_e;

  localparam int B_RXTRG  = 0;
  localparam int B_RXEMP  = 1;
  localparam int B_RXFUL  = 2;
  localparam int B_TXEMP  = 3;
  localparam int B_TXFUL  = 4;
  localparam int B_RXOVR  = 5;
  localparam int B_FRAME  = 6;
  localparam int B_PARITY = 7;
  localparam int B_TMO    = 8;
  localparam int B_MODEM  = 9;
  localparam int B_TXTRG_STK  = 10;
  localparam int B_TXOVR  = 12;
  localparam int B_TXTRG_LIVE = 13;
  localparam int N_FIFO_BITS  = 5;
endpackage

// File: rtl/uart_isu_live.sv
module uart_isu_live
  import uart_isu_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic [CNT_W-1:0] tx_count_i,
  input  logic [CNT_W-1:0] rx_trig_i,
  input  logic [CNT_W-1:0] tx_trig_i,
  output logic [REG_W-1:0] live_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  always_comb begin
    live_o               = '0;
    live_o[B_RXTRG]      = (rx_count_i >= rx_trig_i);
    live_o[B_RXEMP]      = (rx_count_i == '0);
    live_o[B_RXFUL]      = (rx_count_i == FULL);
    live_o[B_TXEMP]      = (tx_count_i == '0);
    live_o[B_TXFUL]      = (tx_count_i == FULL);
    live_o[B_TXTRG_LIVE] = (tx_count_i >= tx_trig_i);
  end
endmodule

// File: rtl/uart_isu_setclr.sv
module uart_isu_setclr
  import uart_isu_pkg::*;
#(
  parameter logic [REG_W-1:0] KEEP = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] set_i,
  input  logic [REG_W-1:0] clr_i,
  output logic [REG_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= ((q_o & ~clr_i) | set_i) & KEEP;
  end
endmodule

// File: rtl/uart_isu_top.sv
module uart_isu_top
  import uart_isu_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int TRIG_RST = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic [CNT_W-1:0] tx_count_i,
  input  logic             evt_rx_ovr_i,
  input  logic             evt_frame_i,
  input  logic             evt_parity_i,
  input  logic             evt_timeout_i,
  input  logic             evt_modem_i,
  input  logic             evt_tx_ovr_i,
  input  logic             wr_en_i,
  input  logic [2:0]       addr_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             irq_o
);
  localparam logic [REG_W-1:0] STK_KEEP = REG_W'(32'h0000_17FF);

  logic [REG_W-1:0] live, stk_set, stk_clr, stk_q;
  logic [REG_W-1:0] msk_set, msk_clr, mask_q;
  logic [CNT_W-1:0] rx_trig_q, tx_trig_q;
  isu_addr_e        a;

  assign a = isu_addr_e'(addr_i);

  uart_isu_live #(.DEPTH(DEPTH)) u_live (
    .rx_count_i(rx_count_i), .tx_count_i(tx_count_i),
    .rx_trig_i(rx_trig_q),   .tx_trig_i(tx_trig_q),
    .live_o(live)
  );

  always_comb begin
    stk_set = '0;
    for (int i = 0; i < N_FIFO_BITS; i++) stk_set[i] = live[i];
    stk_set[B_TXTRG_STK] = live[B_TXTRG_LIVE];
    stk_set[B_RXOVR]     = evt_rx_ovr_i;
    stk_set[B_FRAME]     = evt_frame_i;
    stk_set[B_PARITY]    = evt_parity_i;
    stk_set[B_TMO]       = evt_timeout_i;
    stk_set[B_MODEM]     = evt_modem_i;
    stk_set[B_TXOVR]     = evt_tx_ovr_i;
    stk_clr = (wr_en_i && a == A_STAT) ? wr_data_i : '0;
    msk_set = (wr_en_i && a == A_MSET) ? wr_data_i : '0;
    msk_clr = (wr_en_i && a == A_MCLR) ? wr_data_i : '0;
  end

  uart_isu_setclr #(.KEEP(STK_KEEP)) u_sticky (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(stk_set), .clr_i(stk_clr), .q_o(stk_q)
  );

  uart_isu_setclr #(.KEEP('1)) u_mask (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(msk_set), .clr_i(msk_clr), .q_o(mask_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_trig_q <= CNT_W'(TRIG_RST);
      tx_trig_q <= CNT_W'(TRIG_RST);
    end else if (wr_en_i) begin
      if (a == A_RXTRG) rx_trig_q <= wr_data_i[CNT_W-1:0];
      if (a == A_TXTRG) tx_trig_q <= wr_data_i[CNT_W-1:0];
    end
  end

  always_comb begin
    unique case (a)
      A_MSET, A_MCLR, A_NONE: rd_data_o = '0;
      A_MASK:  rd_data_o = mask_q;
      A_STAT:  rd_data_o = stk_q;
      A_LIVE:  rd_data_o = live;
      A_RXTRG: rd_data_o = REG_W'(rx_trig_q);
      A_TXTRG: rd_data_o = REG_W'(tx_trig_q);
      default: rd_data_o = '0;
    endcase
  end

  assign irq_o = |(mask_q & stk_q);
endmodule

// File: rtl/uart_isu_chk.sv
module uart_isu_chk
  import uart_isu_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] rx_count_i,
  input logic [CNT_W-1:0] tx_count_i,
  input logic [CNT_W-1:0] tx_trig_q,
  input logic             evt_frame_i,
  input logic             evt_rx_ovr_i,
  input logic             wr_en_i,
  input logic [2:0]       addr_i,
  input logic [REG_W-1:0] wr_data_i,
  input logic [REG_W-1:0] mask_q,
  input logic [REG_W-1:0] stk_q,
  input logic             irq_o
);
  logic stat_wr;
  assign stat_wr = wr_en_i && addr_i == 3'(A_STAT);

  p_txtrig_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_count_i >= tx_trig_q) |=> (stk_q[B_TXTRG_STK] && !stk_q[B_TXTRG_LIVE]));

  p_rxempty_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_count_i == '0) |=> stk_q[B_RXEMP]);

  p_sticky_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_wr |=> ((stk_q & $past(stk_q)) == $past(stk_q)));

  p_mask_ro_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 3'(A_MASK)) |=> $stable(mask_q));

  p_mask_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 3'(A_MSET)) |=> ((mask_q & $past(wr_data_i)) == $past(wr_data_i)));

  p_frame_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_frame_i |=> stk_q[B_FRAME]);

  p_all_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 3'(A_MCLR) && wr_data_i == '1) |=> !irq_o);

  p_event_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_rx_ovr_i && stat_wr) |=> stk_q[B_RXOVR]);
endmodule

bind uart_isu_top uart_isu_chk #(.CNT_W(CNT_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .rx_count_i(rx_count_i), .tx_count_i(tx_count_i),
  .tx_trig_q(tx_trig_q), .evt_frame_i(evt_frame_i), .evt_rx_ovr_i(evt_rx_ovr_i),
  .wr_en_i(wr_en_i), .addr_i(addr_i), .wr_data_i(wr_data_i),
  .mask_q(mask_q), .stk_q(stk_q), .irq_o(irq_o)
);

// File: tb/uart_isu_top_tb_top.sv
module uart_isu_top_tb_top;
  localparam int CLK_P = 10;
  localparam int DEPTH = 64;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int NV = 6;
  // {rx_count, tx_count, expected live word}
  localparam logic [CW+CW+31:0] VEC [NV] = '{
    {7'd0,  7'd0,  32'h0000_000A},
    {7'd32, 7'd0,  32'h0000_0009},
    {7'd64, 7'd64, 32'h0000_2015},
    {7'd5,  7'd40, 32'h0000_2000},
    {7'd31, 7'd31, 32'h0000_0000},
    {7'd64, 7'd0,  32'h0000_000D}
  };

  logic clk = 0, rst_n = 0;
  logic [CW-1:0] rxc = 0, txc = 0;
  logic e_ro = 0, e_fr = 0, e_pa = 0, e_to = 0, e_mo = 0, e_tx = 0;
  logic we = 0;
  logic [2:0] addr = 0;
  logic [31:0] wd = 0, rd;
  logic irq;
  int checks = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  uart_isu_top #(.DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rx_count_i(rxc), .tx_count_i(txc),
    .evt_rx_ovr_i(e_ro), .evt_frame_i(e_fr), .evt_parity_i(e_pa),
    .evt_timeout_i(e_to), .evt_modem_i(e_mo), .evt_tx_ovr_i(e_tx),
    .wr_en_i(we), .addr_i(addr), .wr_data_i(wd), .rd_data_o(rd), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wd = d;
    @(posedge clk); #1; we = 0;
  endtask

  task automatic rdchk(input string req, input logic [2:0] a, input logic [31:0] exp);
    addr = a; #1; chk(req, rd, exp);
  endtask

  task automatic idle(); @(negedge clk); @(posedge clk); #1; endtask

  initial begin
    #(CLK_P * 20000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rxc = 10; txc = 10;
    #(CLK_P*3); rst_n = 1; #1;
    // R8 reset values
    rdchk("R8 mask", 3'd2, 0);
    rdchk("R8 sticky", 3'd3, 0);
    rdchk("R8 rx trig", 3'd5, 32);
    rdchk("R8 tx trig", 3'd6, 32);
    chk("R7 irq at reset", {31'b0, irq}, 0);

    // R1 table walk of live word
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      rxc = VEC[i][CW+CW+31:CW+32]; txc = VEC[i][CW+31:32];
      rdchk("R1 live", 3'd4, VEC[i][31:0]);
    end

    // R3 sticky from last vector (rx=64, tx=0): bits 0,2,3 at least
    @(posedge clk); #1;
    addr = 3'd3; #1; chk("R3 sticky set", rd & 32'h0000_000D, 32'h0000_000D);
    // R2 bit 10 set by earlier tx>=32, bit 13 clear
    chk("R2 sticky tx trig", rd & 32'h0000_2400, 32'h0000_0400);
    @(negedge clk); rxc = 10; txc = 10;
    idle();
    rdchk("R3 sticky holds", 3'd3, 32'h0000_041F);

    // R4 write-1-to-clear partial then all
    wr(3'd3, 32'h0000_0003);
    rdchk("R4 partial clear", 3'd3, 32'h0000_041C);
    wr(3'd3, 32'hFFFF_FFFF);
    rdchk("R4 full clear", 3'd3, 0);

    // R6 events
    @(negedge clk); e_pa = 1; @(posedge clk); #1; e_pa = 0;
    rdchk("R6 parity bit7", 3'd3, 32'h0000_0080);
    @(negedge clk); e_fr = 1; e_ro = 1; e_to = 1; @(posedge clk); #1; e_fr = 0; e_ro = 0; e_to = 0;
    rdchk("R6 frame/ovr/timeout", 3'd3, 32'h0000_01E0);
    @(negedge clk); e_mo = 1; e_tx = 1; @(posedge clk); #1; e_mo = 0; e_tx = 0;
    rdchk("R6 modem/tx ovr", 3'd3, 32'h0000_13E0);

    // R5 mask set/clear/ignore, R7 irq
    chk("R7 no mask no irq", {31'b0, irq}, 0);
    wr(3'd0, 32'h0000_1000);
    rdchk("R5 mask set", 3'd2, 32'h0000_1000);
    chk("R7 irq on", {31'b0, irq}, 1);
    wr(3'd2, 32'hFFFF_FFFF);
    rdchk("R5 mask write ignored", 3'd2, 32'h0000_1000);
    wr(3'd0, 32'h8000_0001);
    rdchk("R5 mask OR", 3'd2, 32'h8000_1001);
    wr(3'd1, 32'h0000_1000);
    rdchk("R5 mask clear", 3'd2, 32'h8000_0001);
    chk("R7 irq off (masked bits not set)", {31'b0, irq}, 0);
    wr(3'd3, 32'hFFFF_FFFF);

    // R9 event wins over clear
    @(negedge clk); e_ro = 1; we = 1; addr = 3'd3; wd = 32'h0000_0020;
    @(posedge clk); #1; e_ro = 0; we = 0;
    rdchk("R9 event wins", 3'd3, 32'h0000_0020);

    // R10 unused address and trigger width
    rdchk("R10 addr7", 3'd7, 0);
    rdchk("R10 addr0 reads 0", 3'd0, 0);
    wr(3'd5, 32'hFFFF_FF08);
    rdchk("R10 rx trig truncated", 3'd5, 32'h0000_0008);
    rdchk("R1 rx trig moved", 3'd4, 32'h0000_0001);
    // R2 tx trigger lowered -> live 13, sticky 10
    wr(3'd6, 32'd4);
    rdchk("R2 live bit13", 3'd4, 32'h0000_2001);
    idle();
    addr = 3'd3; #1; chk("R2 sticky bit10", rd & 32'h0000_2400, 32'h0000_0400);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule